// File: doc/BRIEF.md
# Banked GPIO Port Controller

This block gives a processor control of a parameterised set of general-purpose pins through a small memory-mapped register bus. Pins are packed 32 to a bank word. Each register kind occupies a contiguous run of bank words that starts at a fixed base offset. Software can read the synchronised pad levels, choose each pin's direction and set the glitch-filter bypass bits. It changes output values only through two write-only registers. One register raises the pins whose bits are 1 and the other lowers them. No read-modify-write is needed, so two agents touching different pins of one bank cannot undo each other's work.

The pads are driven from an output-enable vector and an output-value vector. The bypass vector goes to a neighbouring glitch filter. Pad inputs pass through a two-flop synchroniser before they reach the read path. Every bus access, decoded or not, completes with a ready pulse one cycle after the request.

Top module: `gpio_bank_port`

## Requirements
- R1: After reset, pad_oe, pad_out and pad_filt_bypass are all zero, bus_rdy is low, and reading any direction or bypass word returns zero.
- R2: A pin with index p lives in bank p/32 at bit p%32. The register word for bank b sits at the kind's base plus 4*b. The bases are level 0x004, direction 0x01C, set 0x034, clear 0x04C and bypass 0x094. An address decodes only if its two low bits are zero.
- R3: A write to a set word drives pad_out high for every pin whose data bit is 1 and leaves the other pins unchanged.
- R4: A write to a clear word drives pad_out low for every pin whose data bit is 1 and leaves the other pins unchanged.
- R5: A direction word reads back as written and appears on pad_oe, where 1 means output and 0 means input. pad_oe changes only on a direction write.
- R6: A bypass word reads back as written and appears on pad_filt_bypass.
- R7: A level read returns the synchronised pad input for every pin, whatever its direction. A read accepted at the first or second rising edge after a pad change still returns the old value. A read accepted at the third edge returns the new value.
- R8: Reads of the set and clear words return zero. Writes to level words change no pin state.
- R9: An address that does not decode reads as zero and a write to it changes no state. The default layout leaves 0x000, 0x064 to 0x093 and 0x0AC upward undecoded.
- R10: bus_rdy is high in exactly the cycle after each cycle in which bus_sel is high, and bus_rdata is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request, one access per cycle held high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rdy |
| bus_rdy | output | 1 | Access complete |
| pad_in | input | NUM_PINS (192) | Asynchronous pad inputs |
| pad_oe | output | NUM_PINS (192) | Output enable per pin |
| pad_out | output | NUM_PINS (192) | Output value per pin |
| pad_filt_bypass | output | NUM_PINS (192) | Glitch-filter bypass per pin |

## Verification
A pad input can change while a level read of that bank is being accepted, so the synchroniser and the read path act in the same cycles. The bench provokes this with a back-to-back burst of level reads. The burst starts in the same cycle that a pad toggles, on a pin that is configured as an output. The bench expects the old value on the first two reads and the new value on the third, which pins down the two-stage latency. Random traffic mixes pad changes, writes to every register kind and undecoded accesses. The bench compares every read and every pad vector with a model held in the bench.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned BANK_W = 32;

  localparam int unsigned BASE_LEVEL = 32'h004;
  localparam int unsigned BASE_DIR   = 32'h01C;
  localparam int unsigned BASE_SET   = 32'h034;
  localparam int unsigned BASE_CLR   = 32'h04C;
  localparam int unsigned BASE_BYP   = 32'h094;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_LEVEL,
    KIND_DIR,
    KIND_SET,
    KIND_CLR,
    KIND_BYP
  } reg_kind_e;

  // word-aligned address inside the run of nb bank words starting at base
  function automatic logic in_run(int unsigned a, int unsigned base, int unsigned nb);
    return ((a % 4) == 0) && (a >= base) && ((a - base) < 4 * nb);
  endfunction

  // bank number of an address inside a run
  function automatic int unsigned bank_in_run(int unsigned a, int unsigned base);
    return (a - base) >> 2;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_BANKS  = 6,
  parameter int unsigned BANK_IDX_W = 3
) (
  input  logic [ADDR_W-1:0]     addr,
  output reg_kind_e             kind,
  output logic [BANK_IDX_W-1:0] bank
);

  logic [31:0] a_ext;
  assign a_ext = 32'(addr);

  always_comb begin
    kind = KIND_NONE;
    bank = '0;
    if (in_run(a_ext, BASE_LEVEL, NUM_BANKS)) begin
      kind = KIND_LEVEL;
      bank = BANK_IDX_W'(bank_in_run(a_ext, BASE_LEVEL));
    end else if (in_run(a_ext, BASE_DIR, NUM_BANKS)) begin
      kind = KIND_DIR;
      bank = BANK_IDX_W'(bank_in_run(a_ext, BASE_DIR));
    end else if (in_run(a_ext, BASE_SET, NUM_BANKS)) begin
      kind = KIND_SET;
      bank = BANK_IDX_W'(bank_in_run(a_ext, BASE_SET));
    end else if (in_run(a_ext, BASE_CLR, NUM_BANKS)) begin
      kind = KIND_CLR;
      bank = BANK_IDX_W'(bank_in_run(a_ext, BASE_CLR));
    end else if (in_run(a_ext, BASE_BYP, NUM_BANKS)) begin
      kind = KIND_BYP;
      bank = BANK_IDX_W'(bank_in_run(a_ext, BASE_BYP));
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 192,
  parameter int unsigned NUM_BANKS  = 6,
  parameter int unsigned BANK_IDX_W = 3,
  localparam int unsigned TOT_W     = NUM_BANKS * BANK_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  reg_kind_e             kind,
  input  logic [BANK_IDX_W-1:0] bank,
  input  logic [BANK_W-1:0]     wdata,
  output logic [TOT_W-1:0]      dir_q,
  output logic [TOT_W-1:0]      out_q,
  output logic [TOT_W-1:0]      byp_q,
  output logic [TOT_W-1:0]      set_mask,
  output logic [TOT_W-1:0]      clr_mask
);

  // lanes of bank b that map to real pins
  function automatic logic [BANK_W-1:0] lane_valid(int unsigned b);
    logic [BANK_W-1:0] m;
    for (int unsigned i = 0; i < BANK_W; i++) begin
      m[i] = ((b * BANK_W + i) < NUM_PINS);
    end
    return m;
  endfunction

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] VMASK = lane_valid(b);
    logic hit;
    assign hit = wr_en && (int'(bank) == b);

    assign set_mask[b*BANK_W +: BANK_W] = (hit && kind == KIND_SET) ? (wdata & VMASK) : '0;
    assign clr_mask[b*BANK_W +: BANK_W] = (hit && kind == KIND_CLR) ? (wdata & VMASK) : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_q[b*BANK_W +: BANK_W] <= '0;
        out_q[b*BANK_W +: BANK_W] <= '0;
        byp_q[b*BANK_W +: BANK_W] <= '0;
      end else begin
        if (hit && kind == KIND_DIR) dir_q[b*BANK_W +: BANK_W] <= wdata & VMASK;
        if (hit && kind == KIND_BYP) byp_q[b*BANK_W +: BANK_W] <= wdata & VMASK;
        // set wins over clear for a shared bit
        out_q[b*BANK_W +: BANK_W] <= (out_q[b*BANK_W +: BANK_W] & ~clr_mask[b*BANK_W +: BANK_W])
                                     | set_mask[b*BANK_W +: BANK_W];
      end
    end
  end

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 192,
  parameter int unsigned ADDR_W      = 12,
  localparam int unsigned NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W,
  localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned TOT_W      = NUM_BANKS * BANK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rdy,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_filt_bypass
);

  reg_kind_e             kind;
  logic [BANK_IDX_W-1:0] bank;
  logic [NUM_PINS-1:0]   lvl_sync;
  logic [TOT_W-1:0]      lvl_wide;
  logic [TOT_W-1:0]      dir_q, out_q, byp_q, set_mask, clr_mask;
  logic [31:0]           rd_word;
  logic                  rdy_q;
  logic [31:0]           rdata_q;

  // named events for the checker
  logic                  wr_any;
  logic                  dir_wr;
  logic                  zero_rd;
  logic [NUM_PINS-1:0]   set_pins;
  logic [NUM_PINS-1:0]   clr_pins;

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_IDX_W(BANK_IDX_W)
  ) u_dec (
    .addr(bus_addr), .kind(kind), .bank(bank)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(lvl_sync)
  );

  assign wr_any = bus_sel && bus_we;

  gpio_bank_regs #(
    .NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS), .BANK_IDX_W(BANK_IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_any), .kind(kind), .bank(bank),
    .wdata(bus_wdata), .dir_q(dir_q), .out_q(out_q), .byp_q(byp_q),
    .set_mask(set_mask), .clr_mask(clr_mask)
  );

  always_comb begin
    lvl_wide = '0;
    lvl_wide[NUM_PINS-1:0] = lvl_sync;
  end

  always_comb begin
    case (kind)
      KIND_LEVEL: rd_word = lvl_wide[int'(bank)*BANK_W +: BANK_W];
      KIND_DIR:   rd_word = dir_q[int'(bank)*BANK_W +: BANK_W];
      KIND_BYP:   rd_word = byp_q[int'(bank)*BANK_W +: BANK_W];
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdy_q   <= bus_sel;
      rdata_q <= (bus_sel && !bus_we) ? rd_word : '0;
    end
  end

  assign dir_wr   = wr_any && (kind == KIND_DIR);
  assign zero_rd  = bus_sel && !bus_we &&
                    (kind == KIND_SET || kind == KIND_CLR || kind == KIND_NONE);
  assign set_pins = set_mask[NUM_PINS-1:0];
  assign clr_pins = clr_mask[NUM_PINS-1:0];

  assign bus_rdy         = rdy_q;
  assign bus_rdata       = rdata_q;
  assign pad_oe          = dir_q[NUM_PINS-1:0];
  assign pad_out         = out_q[NUM_PINS-1:0];
  assign pad_filt_bypass = byp_q[NUM_PINS-1:0];

endmodule

// File: rtl/gpio_bank_port_chk.sv
module gpio_bank_port_chk #(
  parameter int unsigned NUM_PINS = 192
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_rdy,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] set_pins,
  input logic [NUM_PINS-1:0] clr_pins,
  input logic                dir_wr,
  input logic                zero_rd
);

  // R10
  rdy_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_rdy);

  // R10
  rdy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_rdy);

  // R3
  set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pins) |=> ((pad_out & $past(set_pins)) == $past(set_pins)));

  // R4
  clr_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_pins) && !(|set_pins)) |=> ((pad_out & $past(clr_pins)) == '0));

  // R3 R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_pins) && !(|clr_pins)) |=> $stable(pad_out));

  // R5
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(pad_oe));

  // R8 R9
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_rd |=> (bus_rdata == '0));

endmodule

bind gpio_bank_port gpio_bank_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rdy(bus_rdy),
  .bus_rdata(bus_rdata), .pad_oe(pad_oe), .pad_out(pad_out),
  .set_pins(set_pins), .clr_pins(clr_pins), .dir_wr(dir_wr), .zero_rd(zero_rd)
);

// File: tb/gpio_bank_port_tb.sv
module gpio_bank_port_tb;

  localparam int NP = 192;
  localparam int NB = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_we;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          bus_rdy;
  logic [NP-1:0] pad_in, pad_oe, pad_out, pad_filt_bypass;

  logic [NP-1:0] m_dir, m_out, m_byp;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_bank_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_filt_bypass(pad_filt_bypass)
  );

  // kinds: 0 level, 1 dir, 2 set, 3 clear, 4 bypass
  function automatic logic [11:0] word_addr(int kind, int b);
    int base;
    case (kind)
      0: base = 'h004;
      1: base = 'h01C;
      2: base = 'h034;
      3: base = 'h04C;
      default: base = 'h094;
    endcase
    return 12'(base + 4 * b);
  endfunction

  function automatic logic [31:0] expect_read(int kind, int b);
    case (kind)
      0: return pad_in[b*32 +: 32];
      1: return m_dir[b*32 +: 32];
      4: return m_byp[b*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(int kind, int b, logic [31:0] d);
    case (kind)
      1: m_dir[b*32 +: 32] = d;
      2: m_out[b*32 +: 32] = m_out[b*32 +: 32] | d;
      3: m_out[b*32 +: 32] = m_out[b*32 +: 32] & ~d;
      4: m_byp[b*32 +: 32] = d;
      default: ;
    endcase
  endtask

  task automatic chk(string rq, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk_pads(string rq);
    chk({rq, " pad_oe"}, pad_oe, m_dir);
    chk({rq, " pad_out"}, pad_out, m_out);
    chk({rq, " pad_filt_bypass"}, pad_filt_bypass, m_byp);
  endtask

  task automatic xfer(logic we, logic [11:0] a, logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    rd = bus_rdata;
    chk("R10 rdy", NP'(bus_rdy), NP'(1));
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr_kind(int kind, int b, logic [31:0] d);
    logic [31:0] rd;
    xfer(1'b1, word_addr(kind, b), d, rd);
    model_write(kind, b, d);
  endtask

  task automatic rd_kind(string rq, int kind, int b);
    logic [31:0] rd;
    xfer(1'b0, word_addr(kind, b), 32'h0, rd);
    chk(rq, NP'(rd), NP'(expect_read(kind, b)));
  endtask

  function automatic logic [11:0] bad_addr();
    case ($urandom % 4)
      0: return 12'h000;
      1: return 12'(32'h064 + 4 * ($urandom % 12));
      2: return 12'(32'h0AC + 4 * ($urandom % 200));
      default: return 12'(word_addr($urandom % 5, $urandom % NB) + 1 + ($urandom % 3));
    endcase
  endfunction

  function automatic logic [NP-1:0] rand_pins();
    logic [NP-1:0] v;
    for (int i = 0; i < NB; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; m_dir = '0; m_out = '0; m_byp = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_pads("R1");
    chk("R1 rdy", NP'(bus_rdy), NP'(0));
    rst_n = 1'b1;
    rd_kind("R1 dir read", 1, 0);
    rd_kind("R1 byp read", 4, 5);

    // R5 direction
    wr_kind(1, 2, 32'hA5A5_0F0F);
    chk_pads("R5");
    rd_kind("R5 dir readback", 1, 2);

    // R2 R3 last bank, both edge lanes
    wr_kind(2, 5, 32'h8000_0001);
    chk("R2 R3 pin191", NP'(pad_out[191]), NP'(1));
    chk("R2 R3 pin160", NP'(pad_out[160]), NP'(1));
    // R4
    wr_kind(3, 5, 32'h0000_0001);
    chk_pads("R4");

    // R6 bypass
    wr_kind(4, 1, 32'h1234_5678);
    chk_pads("R6");
    rd_kind("R6 byp readback", 4, 1);

    // R8 write-only reads zero, level writes ignored
    rd_kind("R8 set read", 2, 5);
    rd_kind("R8 clr read", 3, 5);
    wr_kind(0, 0, 32'hFFFF_FFFF);
    wr_kind(0, 5, 32'hFFFF_FFFF);
    chk_pads("R8 level write");

    // R9 undecoded
    xfer(1'b0, 12'h000, 32'h0, rd); chk("R9 read 0x000", NP'(rd), NP'(0));
    xfer(1'b0, 12'h064, 32'h0, rd); chk("R9 read 0x064", NP'(rd), NP'(0));
    xfer(1'b0, 12'h0AC, 32'h0, rd); chk("R9 read 0x0AC", NP'(rd), NP'(0));
    xfer(1'b0, 12'h01D, 32'h0, rd); chk("R9 misaligned", NP'(rd), NP'(0));
    xfer(1'b1, 12'h0AC, 32'hFFFF_FFFF, rd);
    xfer(1'b1, 12'h01E, 32'hFFFF_FFFF, rd);
    chk_pads("R9 write");

    // R7 pad change meets a read burst; pin 40 is an output
    wr_kind(1, 1, 32'h0000_0100);
    @(negedge clk);
    pad_in[40] = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = word_addr(0, 1);
    @(negedge clk);
    chk("R7 edge1 old", NP'(bus_rdata), NP'(0));
    @(negedge clk);
    chk("R7 edge2 old", NP'(bus_rdata), NP'(0));
    @(negedge clk);
    chk("R7 edge3 new", NP'(bus_rdata), NP'(32'h100));
    chk("R10 burst rdy", NP'(bus_rdy), NP'(1));
    bus_sel = 1'b0;
    @(negedge clk);
    chk("R10 idle rdy", NP'(bus_rdy), NP'(0));

    // random mix
    for (int n = 0; n < 600; n++) begin
      int kind, b;
      if (n % 25 == 0) begin
        @(negedge clk);
        pad_in = rand_pins();
        repeat (3) @(negedge clk);
      end
      kind = $urandom % 6;
      b = $urandom % NB;
      if (kind == 5) begin
        xfer($urandom % 2 == 1, bad_addr(), $urandom, rd);
        chk("R9 random", NP'(rd), NP'(0));
        chk_pads("R9 random");
      end else if ($urandom % 2 == 1) begin
        wr_kind(kind, b, $urandom);
        chk_pads(kind == 2 ? "R3 random" : kind == 3 ? "R4 random" : "R5 R6 R8 random");
      end else begin
        rd_kind(kind == 0 ? "R7 random" : "R2 random", kind, b);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule